// File: doc/BRIEF.md
# Ethernet Frame Stream Classifier

This block sits directly behind a receive MAC. It takes frames as a byte stream, where each byte carries start-of-frame and end-of-frame flags, and sends every frame to one of three destinations. Sample-stream traffic is UDP whose destination port falls inside a reserved window. The block strips the headers from these frames and splits the payload into 48-bit records. Each record leaves as a single valid/ready beat toward a stream controller. The stream number travels on a sideband field, and the beat carries only the I and Q words. Address-resolution frames go unchanged to an ARP resolver port. Every remaining frame goes unchanged to a general "other" port used for control traffic, so no frame is lost.

The header is parsed big-endian and the verdict is taken at the first byte that settles it. The EtherType settles ARP and non-IP frames. The IP protocol byte settles non-UDP frames. For UDP, the destination port settles the frame, and its position comes from the IPv4 header-length field. Bytes that arrive before the verdict are kept in a header store. If the frame is forwarded, the store is replayed to the chosen port, and the rest of the frame then passes straight through. If the frame is a sample stream, the stored header is simply abandoned. When the selected output stalls, the input ready drops, and no byte is lost or repeated.

Controller states: `S_HEAD` (collect header bytes and judge), `S_REPLAY` (replay stored bytes to the ARP or other port), `S_PASS` (pass the rest of a forwarded frame through), `S_DSHDR` (skip the UDP header and capture its length), `S_DSPAY` (assemble payload bytes into a record), `S_DSOUT` (present one record beat), `S_DROP` (discard bytes up to end of frame). Transitions:
- `S_HEAD` goes to `S_REPLAY` on an ARP or other verdict, or when the frame ends before any verdict.
- `S_HEAD` goes to `S_DSHDR` on a sample-stream verdict.
- `S_REPLAY` goes to `S_PASS` after the last stored byte, or to `S_HEAD` if the frame had already ended.
- `S_PASS` returns to `S_HEAD` on end of frame.
- `S_DSHDR` goes to `S_DSPAY` after the eighth UDP header byte, or to `S_DROP` if the UDP length holds no payload.
- `S_DSPAY` goes to `S_DSOUT` when a record completes, to `S_DROP` when the UDP length is used up, or to `S_HEAD` on end of frame.
- `S_DSOUT` goes back to `S_DSPAY`, `S_DROP` or `S_HEAD` once the beat is taken.
- `S_DROP` returns to `S_HEAD` on end of frame.

Top module: `frame_stream_classifier`

## Requirements
- R1: After reset, no output valid is high and `in_ready` is high.
- R2: A frame is a sample stream only when bytes 12..13 (big-endian) equal 0x0800, byte 23 equals 17, and the destination port lies in 30000..30255 inclusive. Its header bytes reach neither the ARP port nor the other port.
- R3: Each 6-byte payload record yields one beat, in arrival order. `ds_index` holds record bytes 0..1, `ds_i` holds bytes 2..3 and `ds_q` holds bytes 4..5, each big-endian.
- R4: A trailing partial record yields no beat. Bytes beyond the UDP length field (UDP header bytes 4..5, which include the 8 header bytes) yield no beat.
- R5: A frame with bytes 12..13 equal to 0x0806 appears whole and unchanged on the ARP port. Start is flagged on its first byte only, and end on its last byte only.
- R6: Every frame that is neither a sample stream nor ARP appears whole and unchanged on the other port, with the same start and end flagging. This covers a different EtherType, a protocol other than 17, a port outside the window, a header-length nibble below 5 (low nibble of byte 14), and a frame that ends before any verdict.
- R7: The UDP destination port is read from bytes 14+4·IHL+2 and 14+4·IHL+3, where IHL is the low nibble of byte 14.
- R8: While an output is valid and not ready, it stays valid with unchanged content. While a record beat is pending, `in_ready` is low. No byte is lost or duplicated under random backpressure.
- R9: At most one of the three output valids is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Received frame byte |
| in_valid | input | 1 | Byte present |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_ready | output | 1 | Byte accepted this cycle when high with `in_valid` |
| ds_index | output | WORD | Stream index sideband of the current record |
| ds_i | output | WORD | In-phase sample word |
| ds_q | output | WORD | Quadrature sample word |
| ds_valid | output | 1 | Record beat present |
| ds_ready | input | 1 | Stream controller accepts the beat |
| arp_data | output | 8 | Forwarded ARP frame byte |
| arp_sof | output | 1 | First byte of the ARP frame |
| arp_eof | output | 1 | Last byte of the ARP frame |
| arp_valid | output | 1 | ARP byte present |
| arp_ready | input | 1 | ARP resolver accepts the byte |
| oth_data | output | 8 | Forwarded other-frame byte |
| oth_sof | output | 1 | First byte of the frame |
| oth_eof | output | 1 | Last byte of the frame |
| oth_valid | output | 1 | Other byte present |
| oth_ready | input | 1 | Control path accepts the byte |

## Verification
The hold properties on the ARP and other ports assume that the upstream source keeps `in_data`, `in_sof` and `in_eof` steady while `in_valid` is high and `in_ready` is low. During pass-through those outputs are the input seen through a wire. The checks also assume well-formed frames, with a start flag on the first byte and an end flag on the last. The bench driver presents each byte and holds it until a cycle in which `in_ready` was high. It always flags the first and last byte of a frame and never starts a new frame before the previous end. This keeps every stimulus, including the back-to-back frames sent under random ready patterns, inside those assumptions.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    typedef enum logic [2:0] {
        S_HEAD,
        S_REPLAY,
        S_PASS,
        S_DSHDR,
        S_DSPAY,
        S_DSOUT,
        S_DROP
    } fsc_state_e;

    typedef enum logic [1:0] {
        D_NONE,
        D_DATA,
        D_ARP,
        D_OTHER
    } fsc_dest_e;

    localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
    localparam logic [15:0] ETYPE_ARP  = 16'h0806;
    localparam logic [7:0]  PROTO_UDP  = 8'd17;

endpackage

// File: rtl/fsc_hdr_buf.sv
// Byte store holding the header bytes seen before the routing verdict.
module fsc_hdr_buf #(
    parameter  int DEPTH = 78,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/fsc_rec_pack.sv
// Shifts payload bytes into one index/I/Q record, big-endian.
module fsc_rec_pack #(
    parameter  int WORD = 16,
    localparam int NB   = 3 * WORD / 8,
    localparam int PW   = $clog2(NB)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            shift_en,
    input  logic [7:0]      din,
    output logic            at_last,
    output logic [WORD-1:0] idx,
    output logic [WORD-1:0] smp_i,
    output logic [WORD-1:0] smp_q
);

    logic [3*WORD-1:0] sr;
    logic [PW-1:0]     pos;

    assign at_last = (pos == PW'(NB - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr  <= '0;
            pos <= '0;
        end else if (clr) begin
            pos <= '0;
        end else if (shift_en) begin
            sr  <= {sr[3*WORD-9:0], din};
            pos <= at_last ? '0 : pos + PW'(1);
        end
    end

    assign idx   = sr[3*WORD-1 -: WORD];
    assign smp_i = sr[2*WORD-1 -: WORD];
    assign smp_q = sr[WORD-1:0];

endmodule

// File: rtl/frame_stream_classifier.sv
module frame_stream_classifier
    import fsc_pkg::*;
#(
    parameter int MAX_IHL = 15,
    parameter int PORT_LO = 30000,
    parameter int PORT_HI = 30255,
    parameter int WORD    = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      in_data,
    input  logic            in_valid,
    input  logic            in_sof,
    input  logic            in_eof,
    output logic            in_ready,
    output logic [WORD-1:0] ds_index,
    output logic [WORD-1:0] ds_i,
    output logic [WORD-1:0] ds_q,
    output logic            ds_valid,
    input  logic            ds_ready,
    output logic [7:0]      arp_data,
    output logic            arp_sof,
    output logic            arp_eof,
    output logic            arp_valid,
    input  logic            arp_ready,
    output logic [7:0]      oth_data,
    output logic            oth_sof,
    output logic            oth_eof,
    output logic            oth_valid,
    input  logic            oth_ready
);

    // Deepest verdict byte is the low destination-port byte at 14+4*IHL+3.
    localparam int BUF_DEPTH = 14 + 4 * MAX_IHL + 4;
    localparam int BAW       = $clog2(BUF_DEPTH);
    localparam int CW        = $clog2(BUF_DEPTH + 8) + 1;

    fsc_state_e      state, state_n;
    fsc_dest_e       dest, verdict;
    logic [CW-1:0]   cnt, rlen, rd, hdr_end;
    logic            ended;
    logic [7:0]      etype_hi, port_hi, buf_rd;
    logic [3:0]      ihl;
    logic [15:0]     rem, port_w;
    logic            acc, take, sel_ready, shift_en, rec_last, rec_done;
    logic            out_valid, out_sof, out_eof;
    logic [7:0]      out_data;

    assign acc       = in_valid && in_ready;
    assign take      = acc && (cnt != '0 || in_sof);
    assign hdr_end   = CW'(14) + CW'({ihl, 2'b00});
    assign port_w    = {port_hi, in_data};
    assign sel_ready = (dest == D_ARP) ? arp_ready : oth_ready;
    assign shift_en  = (state == S_DSPAY) && acc;
    assign rec_done  = shift_en && rec_last;

    fsc_hdr_buf #(.DEPTH(BUF_DEPTH)) u_hdr (
        .clk     (clk),
        .wr_en   ((state == S_HEAD) && take),
        .wr_addr (cnt[BAW-1:0]),
        .wr_data (in_data),
        .rd_addr (rd[BAW-1:0]),
        .rd_data (buf_rd)
    );

    fsc_rec_pack #(.WORD(WORD)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (state == S_DSHDR),
        .shift_en (shift_en),
        .din      (in_data),
        .at_last  (rec_last),
        .idx      (ds_index),
        .smp_i    (ds_i),
        .smp_q    (ds_q)
    );

    // Verdict for the byte currently offered while collecting the header.
    always_comb begin
        verdict = D_NONE;
        if (cnt == CW'(13)) begin
            if ({etype_hi, in_data} == ETYPE_ARP) begin
                verdict = D_ARP;
            end else if ({etype_hi, in_data} != ETYPE_IPV4) begin
                verdict = D_OTHER;
            end
        end else if (cnt == CW'(14)) begin
            if (in_data[3:0] < 4'd5) begin
                verdict = D_OTHER;
            end
        end else if (cnt == CW'(23)) begin
            if (in_data != PROTO_UDP) begin
                verdict = D_OTHER;
            end
        end else if (cnt > CW'(23) && cnt == hdr_end + CW'(3)) begin
            verdict = (port_w >= 16'(PORT_LO) && port_w <= 16'(PORT_HI)) ? D_DATA : D_OTHER;
        end
    end

    // Next-state logic.
    always_comb begin
        state_n = state;
        unique case (state)
            S_HEAD: begin
                if (take) begin
                    if (verdict == D_DATA) begin
                        state_n = in_eof ? S_HEAD : S_DSHDR;
                    end else if (verdict != D_NONE || in_eof) begin
                        state_n = S_REPLAY;
                    end
                end
            end
            S_REPLAY: begin
                if (sel_ready && rd == rlen - CW'(1)) begin
                    state_n = ended ? S_HEAD : S_PASS;
                end
            end
            S_PASS: begin
                if (acc && in_eof) state_n = S_HEAD;
            end
            S_DSHDR: begin
                if (acc) begin
                    if (in_eof) begin
                        state_n = S_HEAD;
                    end else if (cnt == hdr_end + CW'(7)) begin
                        state_n = (rem > 16'd8) ? S_DSPAY : S_DROP;
                    end
                end
            end
            S_DSPAY: begin
                if (acc) begin
                    if (rec_done)          state_n = S_DSOUT;
                    else if (in_eof)       state_n = S_HEAD;
                    else if (rem == 16'd1) state_n = S_DROP;
                end
            end
            S_DSOUT: begin
                if (ds_ready) begin
                    if (ended)              state_n = S_HEAD;
                    else if (rem == 16'd0)  state_n = S_DROP;
                    else                    state_n = S_DSPAY;
                end
            end
            S_DROP: begin
                if (acc && in_eof) state_n = S_HEAD;
            end
            default: state_n = S_HEAD;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_HEAD;
        else        state <= state_n;
    end

    // Datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            rlen     <= '0;
            rd       <= '0;
            ended    <= 1'b0;
            dest     <= D_NONE;
            etype_hi <= '0;
            ihl      <= '0;
            port_hi  <= '0;
            rem      <= '0;
        end else begin
            unique case (state)
                S_HEAD: begin
                    if (take) begin
                        if (cnt == CW'(12)) etype_hi <= in_data;
                        if (cnt == CW'(14)) ihl <= in_data[3:0];
                        if (cnt > CW'(23) && cnt == hdr_end + CW'(2)) port_hi <= in_data;
                        rlen  <= cnt + CW'(1);
                        rd    <= '0;
                        ended <= in_eof;
                        dest  <= (verdict == D_NONE) ? D_OTHER : verdict;
                        cnt   <= in_eof ? '0 : cnt + CW'(1);
                    end
                end
                S_REPLAY: begin
                    if (sel_ready) rd <= rd + CW'(1);
                end
                S_DSHDR: begin
                    if (acc) begin
                        cnt <= cnt + CW'(1);
                        if (cnt == hdr_end + CW'(4)) rem[15:8] <= in_data;
                        if (cnt == hdr_end + CW'(5)) rem[7:0]  <= in_data;
                        if (cnt == hdr_end + CW'(7)) rem <= rem - 16'd8;
                    end
                end
                S_DSPAY: begin
                    if (acc) begin
                        rem   <= rem - 16'd1;
                        ended <= in_eof;
                    end
                end
                default: ;
            endcase
            if (state != S_HEAD && state_n == S_HEAD) cnt <= '0;
        end
    end

    // Outputs.
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = in_data;
        out_sof   = 1'b0;
        out_eof   = 1'b0;
        ds_valid  = 1'b0;
        unique case (state)
            S_HEAD, S_DSHDR, S_DSPAY, S_DROP: in_ready = 1'b1;
            S_REPLAY: begin
                out_valid = 1'b1;
                out_data  = buf_rd;
                out_sof   = (rd == '0);
                out_eof   = ended && (rd == rlen - CW'(1));
            end
            S_PASS: begin
                in_ready  = sel_ready;
                out_valid = in_valid;
                out_eof   = in_eof;
            end
            S_DSOUT: ds_valid = 1'b1;
            default: ;
        endcase
    end

    assign arp_valid = out_valid && (dest == D_ARP);
    assign oth_valid = out_valid && (dest == D_OTHER);
    assign arp_data  = out_data;
    assign oth_data  = out_data;
    assign arp_sof   = out_sof;
    assign oth_sof   = out_sof;
    assign arp_eof   = out_eof;
    assign oth_eof   = out_eof;

endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
    parameter int WORD = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_ready,
    input logic [WORD-1:0] ds_index,
    input logic [WORD-1:0] ds_i,
    input logic [WORD-1:0] ds_q,
    input logic            ds_valid,
    input logic            ds_ready,
    input logic [7:0]      arp_data,
    input logic            arp_sof,
    input logic            arp_eof,
    input logic            arp_valid,
    input logic            arp_ready,
    input logic [7:0]      oth_data,
    input logic            oth_sof,
    input logic            oth_eof,
    input logic            oth_valid,
    input logic            oth_ready
);

    // R8: a stalled record beat keeps its content
    a_r8_ds_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ds_valid && !ds_ready |=> ds_valid && $stable(ds_index) && $stable(ds_i) && $stable(ds_q));

    // R8: a stalled ARP byte keeps its content
    a_r8_arp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        arp_valid && !arp_ready |=> arp_valid && $stable(arp_data) && $stable(arp_sof) && $stable(arp_eof));

    // R8: a stalled other-port byte keeps its content
    a_r8_oth_hold: assert property (@(posedge clk) disable iff (!rst_n)
        oth_valid && !oth_ready |=> oth_valid && $stable(oth_data) && $stable(oth_sof) && $stable(oth_eof));

    // R8: no input byte is taken while a record beat waits
    a_r8_beat_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
        ds_valid |-> !in_ready);

    // R9: only one destination is offered at a time
    a_r9_single_port: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ds_valid, arp_valid, oth_valid}));

endmodule

bind frame_stream_classifier fsc_checker #(.WORD(WORD)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .ds_index  (ds_index),
    .ds_i      (ds_i),
    .ds_q      (ds_q),
    .ds_valid  (ds_valid),
    .ds_ready  (ds_ready),
    .arp_data  (arp_data),
    .arp_sof   (arp_sof),
    .arp_eof   (arp_eof),
    .arp_valid (arp_valid),
    .arp_ready (arp_ready),
    .oth_data  (oth_data),
    .oth_sof   (oth_sof),
    .oth_eof   (oth_eof),
    .oth_valid (oth_valid),
    .oth_ready (oth_ready)
);

// File: tb/frame_stream_classifier_test.sv
module frame_stream_classifier_test;

    localparam int WORD = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic in_ready;
    logic [WORD-1:0] ds_index, ds_i, ds_q;
    logic ds_valid;
    logic ds_ready = 1'b1;
    logic [7:0] arp_data, oth_data;
    logic arp_sof, arp_eof, arp_valid, oth_sof, oth_eof, oth_valid;
    logic arp_ready = 1'b1, oth_ready = 1'b1;

    int vectors = 0, miscompares = 0;
    int hold_err = 0, multi = 0;

    logic [7:0] frm [256];
    int flen;
    logic [7:0] ref_b [256];
    int ref_len;

    logic [WORD-1:0] c_idx [64], c_i [64], c_q [64];
    int ds_n = 0;
    logic [7:0] a_b [512], o_b [512];
    logic a_s [512], a_e [512], o_s [512], o_e [512];
    int arp_n = 0, oth_n = 0;

    logic p_ds_stall = 1'b0, p_arp_stall = 1'b0, p_oth_stall = 1'b0;
    logic [3*WORD-1:0] p_ds;
    logic [9:0] p_arp, p_oth;

    logic [15:0] lfsr = 16'hACE1;
    bit stall = 1'b0;

    always #5 clk = ~clk;

    frame_stream_classifier uut (
        .clk(clk), .rst_n(rst_n),
        .in_data(in_data), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_ready(in_ready),
        .ds_index(ds_index), .ds_i(ds_i), .ds_q(ds_q), .ds_valid(ds_valid), .ds_ready(ds_ready),
        .arp_data(arp_data), .arp_sof(arp_sof), .arp_eof(arp_eof), .arp_valid(arp_valid), .arp_ready(arp_ready),
        .oth_data(oth_data), .oth_sof(oth_sof), .oth_eof(oth_eof), .oth_valid(oth_valid), .oth_ready(oth_ready)
    );

    // Ready pattern for the three sinks, changed at the falling edge.
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (stall) begin
            ds_ready = lfsr[0]; arp_ready = lfsr[3]; oth_ready = lfsr[7];
        end else begin
            ds_ready = 1'b1; arp_ready = 1'b1; oth_ready = 1'b1;
        end
    end

    // Monitor, sampling just before the rising edge.
    always @(negedge clk) begin
        #4;
        if (rst_n) begin
            if (p_ds_stall && !(ds_valid && {ds_index, ds_i, ds_q} == p_ds)) hold_err++;
            if (p_arp_stall && !(arp_valid && {arp_data, arp_sof, arp_eof} == p_arp)) hold_err++;
            if (p_oth_stall && !(oth_valid && {oth_data, oth_sof, oth_eof} == p_oth)) hold_err++;
            p_ds_stall  = ds_valid && !ds_ready;   p_ds  = {ds_index, ds_i, ds_q};
            p_arp_stall = arp_valid && !arp_ready; p_arp = {arp_data, arp_sof, arp_eof};
            p_oth_stall = oth_valid && !oth_ready; p_oth = {oth_data, oth_sof, oth_eof};
            if (int'(ds_valid) + int'(arp_valid) + int'(oth_valid) > 1) multi++;
            if (ds_valid && ds_ready && ds_n < 64) begin
                c_idx[ds_n] = ds_index; c_i[ds_n] = ds_i; c_q[ds_n] = ds_q; ds_n++;
            end
            if (arp_valid && arp_ready && arp_n < 512) begin
                a_b[arp_n] = arp_data; a_s[arp_n] = arp_sof; a_e[arp_n] = arp_eof; arp_n++;
            end
            if (oth_valid && oth_ready && oth_n < 512) begin
                o_b[oth_n] = oth_data; o_s[oth_n] = oth_sof; o_e[oth_n] = oth_eof; oth_n++;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] e_idx(input int r); return 16'(16'h0100 + r); endfunction
    function automatic logic [15:0] e_i(input int r);   return 16'(16'h1234 + r * 257); endfunction
    function automatic logic [15:0] e_q(input int r);   return 16'(16'hBEEF - r * 3); endfunction

    task automatic fill();
        for (int k = 0; k < 256; k++) frm[k] = 8'(k * 7 + 3);
    endtask

    task automatic build_udp(input int ihl, input int port, input int nrec, input int partial,
                             input int minlen, input int proto);
        int h, plen;
        fill();
        h = 14 + ihl * 4;
        plen = nrec * 6 + partial;
        frm[12] = 8'h08; frm[13] = 8'h00;
        frm[14] = 8'(8'h40 | ihl);
        frm[23] = 8'(proto);
        frm[h+2] = 8'(port >> 8); frm[h+3] = 8'(port);
        frm[h+4] = 8'((plen + 8) >> 8); frm[h+5] = 8'(plen + 8);
        for (int r = 0; r < nrec; r++) begin
            frm[h+8+6*r]   = e_idx(r)[15:8]; frm[h+9+6*r]  = e_idx(r)[7:0];
            frm[h+10+6*r]  = e_i(r)[15:8];   frm[h+11+6*r] = e_i(r)[7:0];
            frm[h+12+6*r]  = e_q(r)[15:8];   frm[h+13+6*r] = e_q(r)[7:0];
        end
        flen = h + 8 + plen;
        if (flen < minlen) flen = minlen;
    endtask

    task automatic snap();
        for (int k = 0; k < 256; k++) ref_b[k] = frm[k];
        ref_len = flen;
    endtask

    task automatic clear_caps();
        ds_n = 0; arp_n = 0; oth_n = 0;
    endtask

    // Presents one frame, holding each byte until it is accepted.
    task automatic send();
        for (int k = 0; k < flen; k++) begin
            bit ok;
            in_valid = 1'b1; in_data = frm[k];
            in_sof = (k == 0); in_eof = (k == flen - 1);
            do begin #4; ok = in_ready; @(negedge clk); end while (!ok);
        end
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic drain();
        repeat (300) @(negedge clk);
    endtask

    task automatic check_ds(input string req, input int nexp);
        chk(req, "beat count", ds_n, nexp);
        for (int r = 0; r < nexp && r < ds_n; r++) begin
            chk(req, "index", int'(c_idx[r]), int'(e_idx(r)));
            chk(req, "I word", int'(c_i[r]), int'(e_i(r)));
            chk(req, "Q word", int'(c_q[r]), int'(e_q(r)));
        end
    endtask

    task automatic check_fwd(input string req, input bit use_arp);
        int n, bad, sofs, eofs;
        logic [7:0] b;
        logic s, e;
        bad = 0; sofs = 0; eofs = 0;
        n = use_arp ? arp_n : oth_n;
        chk(req, "byte count", n, ref_len);
        for (int k = 0; k < n; k++) begin
            b = use_arp ? a_b[k] : o_b[k];
            s = use_arp ? a_s[k] : o_s[k];
            e = use_arp ? a_e[k] : o_e[k];
            if (k >= ref_len || b !== ref_b[k]) bad++;
            if (s) begin sofs++; if (k != 0) bad++; end
            if (e) begin eofs++; if (k != n - 1) bad++; end
        end
        chk(req, "byte or flag mismatches", bad, 0);
        chk(req, "start flags", sofs, 1);
        chk(req, "end flags", eofs, 1);
    endtask

    task automatic t_reset();
        #4;
        chk("R1", "in_ready", int'(in_ready), 1);
        chk("R1", "ds_valid", int'(ds_valid), 0);
        chk("R1", "arp_valid", int'(arp_valid), 0);
        chk("R1", "oth_valid", int'(oth_valid), 0);
        @(negedge clk);
    endtask

    task automatic t_ds_basic();
        clear_caps();
        build_udp(5, 30000, 3, 0, 0, 17);
        send(); drain();
        check_ds("R3", 3);
        chk("R2", "header leaked to other", oth_n, 0);
        chk("R2", "header leaked to ARP", arp_n, 0);
    endtask

    task automatic t_ds_partial();
        clear_caps();
        build_udp(7, 30255, 2, 3, 0, 17);
        send(); drain();
        check_ds("R4", 2);
        chk("R7", "other count with IHL 7", oth_n, 0);
    endtask

    task automatic t_ds_pad();
        clear_caps();
        build_udp(5, 30100, 1, 0, 60, 17);
        send(); drain();
        check_ds("R4", 1);
    endtask

    task automatic t_port_low();
        clear_caps();
        build_udp(5, 29999, 2, 0, 0, 17); snap();
        send(); drain();
        check_fwd("R6", 1'b0);
        chk("R2", "beats for port 29999", ds_n, 0);
    endtask

    task automatic t_port_high();
        clear_caps();
        build_udp(5, 30256, 2, 0, 0, 17); snap();
        send(); drain();
        check_fwd("R6", 1'b0);
        chk("R2", "beats for port 30256", ds_n, 0);
    endtask

    task automatic t_ihl_offset();
        clear_caps();
        build_udp(6, 29000, 2, 0, 0, 17);
        frm[36] = 8'h75; frm[37] = 8'h30;
        snap();
        send(); drain();
        check_fwd("R7", 1'b0);
        chk("R7", "beats", ds_n, 0);
    endtask

    task automatic t_not_udp();
        clear_caps();
        build_udp(5, 30000, 2, 0, 0, 6); snap();
        send(); drain();
        check_fwd("R6", 1'b0);
        chk("R6", "beats for protocol 6", ds_n, 0);
        clear_caps();
        build_udp(5, 30000, 2, 0, 0, 17);
        frm[14] = 8'h43; snap();
        send(); drain();
        check_fwd("R6", 1'b0);
        chk("R6", "beats for IHL 3", ds_n, 0);
    endtask

    task automatic t_arp();
        clear_caps();
        fill(); frm[12] = 8'h08; frm[13] = 8'h06; flen = 42; snap();
        send(); drain();
        check_fwd("R5", 1'b1);
        chk("R5", "other count", oth_n, 0);
    endtask

    task automatic t_non_ip();
        clear_caps();
        fill(); frm[12] = 8'h86; frm[13] = 8'hDD; flen = 64; snap();
        send(); drain();
        check_fwd("R6", 1'b0);
        chk("R6", "ARP count", arp_n, 0);
    endtask

    task automatic t_short();
        clear_caps();
        fill(); flen = 10; snap();
        send(); drain();
        check_fwd("R6", 1'b0);
    endtask

    task automatic t_stall();
        logic [7:0] arp_ref [256];
        int arp_len;
        clear_caps();
        stall = 1'b1;
        build_udp(5, 30001, 4, 0, 0, 17);
        send();
        build_udp(5, 40000, 3, 0, 0, 17); snap();
        send();
        fill(); frm[12] = 8'h08; frm[13] = 8'h06; flen = 60;
        for (int k = 0; k < 256; k++) arp_ref[k] = frm[k];
        arp_len = flen;
        send();
        drain();
        stall = 1'b0;
        check_ds("R8", 4);
        check_fwd("R8", 1'b0);
        for (int k = 0; k < 256; k++) ref_b[k] = arp_ref[k];
        ref_len = arp_len;
        check_fwd("R8", 1'b1);
        chk("R8", "stalled output changed", hold_err, 0);
        chk("R9", "cycles with several valids", multi, 0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ds_basic();
        t_ds_partial();
        t_ds_pad();
        t_port_low();
        t_port_high();
        t_ihl_offset();
        t_not_udp();
        t_arp();
        t_non_ip();
        t_short();
        t_stall();
        finish_run();
    end

endmodule